// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is the combinational rotate-and-mask datapath of a 64-bit integer pipeline that numbers bits big-endian, so index 0 is the most significant bit. It left-rotates a source operand and builds a contiguous or wrapping run of ones from a begin index and an end index. It returns the rotated value, the mask and their bitwise AND. The issue logic feeds it operands that are already decoded, and the AND result goes straight to writeback.

A mode input chooses between doubleword and word operation. In word mode the low 32-bit word of the source is copied into both halves of a 64-bit value, and that value goes through the same 64-bit rotator. The 5-bit begin and end indices are moved into the low half of the mask by adding 32. The block does not decode instructions, generate carries, update condition flags or sign-extend.

Top module: `rotmask_unit`

## Requirements
- R1: Bit index 0 is the most significant bit (vector bit 63). When begin ≤ end, `mask_o` has ones at every index from begin to end inclusive and zeros at all other indices.
- R2: When begin > end, `mask_o` wraps: it has ones at indices begin..63 and 0..end, and zeros at indices end+1..begin-1.
- R3: When begin = end, `mask_o` has exactly one bit set, equal to 1 shifted left by (63 − begin).
- R4: With `word_mode_i` = 0, `rot_o` is `src_i` rotated left by `amount_i` (0..63) positions.
- R5: With `word_mode_i` = 1, `rot_o` is {src_i[31:0], src_i[31:0]} rotated left by amount_i[4:0]. Bit 5 of `amount_i` has no effect, and both halves of `rot_o` are equal.
- R6: With `word_mode_i` = 1, the mask uses begin = mb_i[4:0] + 32 and end = me_i[4:0] + 32. Bit 5 of `mb_i` and of `me_i` has no effect.
- R7: `result_o` equals `rot_o & mask_o` for every input combination.
- R8: Fixed vectors. Doubleword mask (37,63) is 0x0000000007ffffff and mask (0,10) is 0xffe0000000000000. Word-mode mask (15,5) is 0xfffffffffc01ffff and word-mode mask (0,0) is 0x0000000080000000. Doubleword rotate of 0xdeadbeef12345678 by 10 is 0xb6fbbc48d159e37a and by 35 is 0x91a2b3c6f56df778. Word-mode rotate of 0xdeadbeef by 10 gives low word 0xb6fbbf7a.
- R9: With `word_mode_i` = 1, src_i[63:32] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| amount_i | input | 6 | Left-rotate amount |
| word_mode_i | input | 1 | 0 = doubleword rotate, 1 = word rotate |
| mb_i | input | 6 | Mask begin index, MSB-first |
| me_i | input | 6 | Mask end index, MSB-first |
| rot_o | output | 64 | Rotated value |
| mask_o | output | 64 | Generated mask |
| result_o | output | 64 | Rotated value ANDed with mask |

## Verification
The assertions assume the inputs are settled, two-state values. They assume that in word mode the operand stage has already forced the indices into the upper half of the index range and the rotate amount below 32. The bench drives every input on the falling clock edge and reads the outputs a short time later, so the combinational paths are always settled when checked. It sweeps all begin/end pairs and all rotate amounts in both modes, with fully defined values. Word-mode stimulus deliberately puts garbage in the upper source half and in bit 5 of the index and amount inputs, which checks that these bits really are don't-care.

// File: rtl/rotmask_pkg.sv
// Package: shared constants and the mode type for the rotate-and-mask unit.
// Assumes a power-of-two data width so the rotate amount is a plain bit field.
package rotmask_pkg;

    // Operating width of the rotator.
    typedef enum logic {
        RM_MODE_DWORD = 1'b0,
        RM_MODE_WORD  = 1'b1
    } rm_mode_e;

    // Default datapath width.
    localparam int unsigned RM_DEF_DATA_W = 64;

endpackage

// File: rtl/rotmask_operand_prep.sv
// Module: rotmask_operand_prep
// Turns the raw operands into the common full-width form. In word mode the
// low half-word is copied into both halves, the rotate amount loses its top
// bit, and both mask indices are moved up by half the width.
// Assumes DATA_W is a power of two of at least 4.
module rotmask_operand_prep
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W = RM_DEF_DATA_W,
    localparam int unsigned SH_W  = $clog2(DATA_W),
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SH_W-1:0]   amount_i,
    input  rm_mode_e          mode_i,
    input  logic [SH_W-1:0]   mb_i,
    input  logic [SH_W-1:0]   me_i,
    output logic [DATA_W-1:0] src_x_o,
    output logic [SH_W-1:0]   amount_x_o,
    output logic [SH_W-1:0]   mb_x_o,
    output logic [SH_W-1:0]   me_x_o
);

    // Select the full-width operand form for the chosen mode.
    always_comb begin
        if (mode_i == RM_MODE_WORD) begin
            src_x_o    = {src_i[HALF_W-1:0], src_i[HALF_W-1:0]};
            amount_x_o = {1'b0, amount_i[SH_W-2:0]};
            mb_x_o     = {1'b1, mb_i[SH_W-2:0]};
            me_x_o     = {1'b1, me_i[SH_W-2:0]};
        end else begin
            src_x_o    = src_i;
            amount_x_o = amount_i;
            mb_x_o     = mb_i;
            me_x_o     = me_i;
        end
    end

    // Word-mode indices must land in the lower half of the mask.
    always_comb begin
        if (mode_i == RM_MODE_WORD) begin
            AST_WORD_IDX_HIGH: assert final (mb_x_o >= SH_W'(HALF_W) && me_x_o >= SH_W'(HALF_W)) else $error("word index not offset"); // R6
            AST_WORD_HALVES_EQ: assert final (src_x_o[DATA_W-1:HALF_W] == src_i[HALF_W-1:0]) else $error("word not duplicated"); // R5
        end
    end

endmodule

// File: rtl/rotmask_rotator.sv
// Module: rotmask_rotator
// Logarithmic left rotator: one stage per amount bit, stage k rotates by
// 2**k when its bit is set. Assumes DATA_W is a power of two, so the
// amount is already reduced modulo the width.
module rotmask_rotator
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W = RM_DEF_DATA_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   amount_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stage [0:SH_W];

    assign stage[0] = data_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        // Conditionally rotate by this stage's power-of-two distance.
        assign stage[k+1] = amount_i[k]
            ? {stage[k][DATA_W-1-STEP:0], stage[k][DATA_W-1:DATA_W-STEP]}
            : stage[k];
    end

    assign data_o = stage[SH_W];

    // A rotation keeps the number of set bits; no rotation means no change.
    always_comb begin
        AST_ROT_POPCOUNT: assert final ($countones(data_o) == $countones(data_i)) else $error("rotate lost bits"); // R4
        if (amount_i == '0) begin
            AST_ROT_ZERO: assert final (data_o == data_i) else $error("zero rotate changed data"); // R4
        end
    end

endmodule

// File: rtl/rotmask_maskgen.sv
// Module: rotmask_maskgen
// Builds a mask from MSB-first begin/end indices. When begin <= end it is
// a run from begin to end; when begin > end the run wraps through both ends.
// Index i maps to vector bit DATA_W-1-i.
module rotmask_maskgen
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W = RM_DEF_DATA_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [SH_W-1:0]   mb_i,
    input  logic [SH_W-1:0]   me_i,
    output logic [DATA_W-1:0] mask_o
);

    logic wrap;

    // Detect a wrapping range once, shared by all bit slices.
    assign wrap = (mb_i > me_i);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic at_or_after_begin;
        logic at_or_before_end;
        // Per-index range membership tests.
        assign at_or_after_begin = (SH_W'(i) >= mb_i);
        assign at_or_before_end  = (SH_W'(i) <= me_i);
        // Combine the tests according to wrap.
        assign mask_o[DATA_W-1-i] = wrap ? (at_or_after_begin | at_or_before_end)
                                         : (at_or_after_begin & at_or_before_end);
    end

    // The endpoints are always in the mask; equal endpoints give one bit.
    always_comb begin
        AST_BEGIN_SET: assert final (mask_o[DATA_W-1-mb_i] && mask_o[DATA_W-1-me_i]) else $error("mask endpoint clear"); // R1
        if (mb_i == me_i) begin
            AST_SINGLE_BIT: assert final ($countones(mask_o) == 1) else $error("single-bit mask wrong"); // R3
        end
        if (wrap) begin
            AST_WRAP_ENDS: assert final (mask_o[DATA_W-1] && mask_o[0]) else $error("wrap mask ends clear"); // R2
        end
    end

endmodule

// File: rtl/rotmask_unit.sv
// Module: rotmask_unit (top)
// Combinational rotate-and-mask datapath: operand preparation, logarithmic
// rotator, mask generator and final AND. Assumes settled two-state inputs;
// there is no state, so no clock or reset is needed.
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int unsigned DATA_W = RM_DEF_DATA_W,
    localparam int unsigned SH_W  = $clog2(DATA_W),
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SH_W-1:0]   amount_i,
    input  logic              word_mode_i,
    input  logic [SH_W-1:0]   mb_i,
    input  logic [SH_W-1:0]   me_i,
    output logic [DATA_W-1:0] rot_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] result_o
);

    rm_mode_e          mode;
    logic [DATA_W-1:0] src_x;
    logic [SH_W-1:0]   amount_x;
    logic [SH_W-1:0]   mb_x;
    logic [SH_W-1:0]   me_x;

    assign mode = rm_mode_e'(word_mode_i);

    rotmask_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .src_i      (src_i),
        .amount_i   (amount_i),
        .mode_i     (mode),
        .mb_i       (mb_i),
        .me_i       (me_i),
        .src_x_o    (src_x),
        .amount_x_o (amount_x),
        .mb_x_o     (mb_x),
        .me_x_o     (me_x)
    );

    rotmask_rotator #(.DATA_W(DATA_W)) u_rot (
        .data_i   (src_x),
        .amount_i (amount_x),
        .data_o   (rot_o)
    );

    rotmask_maskgen #(.DATA_W(DATA_W)) u_mask (
        .mb_i   (mb_x),
        .me_i   (me_x),
        .mask_o (mask_o)
    );

    // Select the rotated bits that fall inside the mask.
    assign result_o = rot_o & mask_o;

    // Cross-block relations between rotator, mask and result.
    always_comb begin
        AST_RESULT_IN_MASK: assert final ((result_o & ~mask_o) == '0) else $error("result outside mask"); // R7
        AST_RESULT_FROM_ROT: assert final ((result_o & ~rot_o) == '0) else $error("result not from rotate"); // R7
        if (word_mode_i) begin
            AST_WORD_ROT_HALVES: assert final (rot_o[DATA_W-1:HALF_W] == rot_o[HALF_W-1:0]) else $error("word rotate halves differ"); // R5
            if (mb_i[SH_W-2:0] <= me_i[SH_W-2:0]) begin
                AST_WORD_MASK_LOW: assert final (mask_o[DATA_W-1:HALF_W] == '0) else $error("word mask in upper half"); // R6
            end
        end
    end

endmodule

// File: tb/rotmask_unit_bench.sv
// Bench: sweeps every begin/end pair and rotate amount in both modes, with
// expected values computed arithmetically.
module rotmask_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src;
    logic [5:0]  amount;
    logic        word_mode;
    logic [5:0]  mb;
    logic [5:0]  me;
    logic [63:0] rot;
    logic [63:0] mask;
    logic [63:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rotmask_unit u_rotmask_unit (
        .src_i       (src),
        .amount_i    (amount),
        .word_mode_i (word_mode),
        .mb_i        (mb),
        .me_i        (me),
        .rot_o       (rot),
        .mask_o      (mask),
        .result_o    (result)
    );

    function automatic logic [63:0] ref_mask(input int b, input int e);
        logic [63:0] lo = 64'hFFFF_FFFF_FFFF_FFFF >> b;
        logic [63:0] hi = 64'hFFFF_FFFF_FFFF_FFFF << (63 - e);
        return (b <= e) ? (lo & hi) : (lo | hi);
    endfunction

    function automatic logic [63:0] ref_rotl(input logic [63:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (64 - n));
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %016h expected %016h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] s, input int a, input bit wm, input int b, input int e);
        @(negedge clk);
        src = s; amount = 6'(a); word_mode = wm; mb = 6'(b); me = 6'(e);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        src = '0; amount = '0; word_mode = 1'b0; mb = '0; me = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #2;
        // Idle inputs: R3 single bit at index 0, R7 zero result.
        chk("R3 idle mask", mask, 64'h8000_0000_0000_0000);
        chk("R7 idle result", result, 64'h0);

        // R8 fixed vectors.
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0, 37, 63);
        chk("R8 mask(37,63)", mask, 64'h0000_0000_07ff_ffff);
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0, 0, 10);
        chk("R8 mask(0,10)", mask, 64'hffe0_0000_0000_0000);
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, 15, 5);
        chk("R8 word mask(15,5)", mask, 64'hffff_ffff_fc01_ffff);
        drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, 0, 0);
        chk("R8 word mask(0,0)", mask, 64'h0000_0000_8000_0000);
        drive(64'hdead_beef_1234_5678, 10, 1'b0, 0, 63);
        chk("R8 rot 10", rot, 64'hb6fb_bc48_d159_e37a);
        drive(64'hdead_beef_1234_5678, 35, 1'b0, 0, 63);
        chk("R8 rot 35", rot, 64'h91a2_b3c6_f56d_f778);
        drive(64'h0000_0000_dead_beef, 10, 1'b1, 0, 31);
        chk("R8 word rot 10", {32'h0, rot[31:0]}, 64'h0000_0000_b6fb_bf7a);

        // R1/R2/R3/R7: every doubleword begin/end pair.
        for (int b = 0; b < 64; b++) begin
            for (int e = 0; e < 64; e++) begin
                drive(64'h0123_4567_89ab_cdef, (b + e) % 64, 1'b0, b, e);
                if (b < e)       chk("R1 mask run", mask, ref_mask(b, e));
                else if (b > e)  chk("R2 mask wrap", mask, ref_mask(b, e));
                else             chk("R3 mask single", mask, 64'h1 << (63 - b));
                chk("R7 result", result,
                    ref_rotl(64'h0123_4567_89ab_cdef, (b + e) % 64) & ref_mask(b, e));
            end
        end

        // R4: every doubleword rotate amount on several patterns.
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 64; n++) begin
                logic [63:0] v;
                v = (p == 0) ? 64'hdead_beef_1234_5678 :
                    (p == 1) ? 64'h8000_0000_0000_0001 : 64'h0000_0000_0000_00f3;
                drive(v, n, 1'b0, 0, 63);
                chk("R4 rotate", rot, ref_rotl(v, n));
            end
        end

        // R5/R9: word rotate, all 64 amount codes, junk upper source half.
        for (int n = 0; n < 64; n++) begin
            logic [63:0] w;
            w = 64'h0000_0000_dead_beef;
            drive(64'ha5a5_5a5a_dead_beef, n, 1'b1, 0, 31);
            chk("R5 word rotate", rot, ref_rotl({w[31:0], w[31:0]}, n % 32));
            chk("R9 upper ignored", result,
                ref_rotl({w[31:0], w[31:0]}, n % 32) & ref_mask(32, 63));
        end

        // R6: word-mode mask for every index code, bit 5 ignored.
        for (int b = 0; b < 64; b++) begin
            for (int e = 0; e < 64; e++) begin
                drive(64'h5555_aaaa_0f0f_3c3c, 0, 1'b1, b, e);
                chk("R6 word mask", mask, ref_mask((b % 32) + 32, (e % 32) + 32));
            end
        end

        finish_run();
    end

endmodule